// File: doc/BRIEF.md
# Nibble-Organised Data Memory with Multi-Width Access

This block is the working data store of a small 4-bit controller. It holds 64 nibbles and sits behind a 12-bit data address. A single request can move one nibble, a pair of nibbles (a byte), or one bit of a nibble. A bit request can test the bit, set it or clear it. Set and clear are done as a read-modify-write within one clock. The address is split into three regions. The bottom 64 locations are backed by the storage array. The top 128 locations are handed to a peripheral request port. Everything in between is unimplemented.

Two region flags mark requests that fall in special windows of the array. One is a small general-register window at the bottom of memory. The other is the upper half of the array, which the controller uses for its call and interrupt stack. Both windows remain ordinary storage. Writes commit on the rising clock edge. Read results, status pulses and the returned bit are registered and appear in the cycle after the request.

Top module: `nram_core`

## Requirements
- R1: Addresses 0x000–0x03F select a nibble of the array. A nibble request (`req_kind` 0, and also the unused code 3) with `req_wr`=1 stores `req_wdata[3:0]`. A nibble read returns the stored nibble on `rd_data[3:0]`, with `rd_data[7:4]`=0.
- R2: A byte request (`req_kind` 1) at an even address A writes or reads a pair of nibbles. Location A carries bits 3:0 and location A+1 carries bits 7:4.
- R3: A byte request at an odd address sets `misalign_err` in the next cycle, for that cycle only. Such a request changes no memory, issues no peripheral request and returns no read.
- R4: A bit request (`req_kind` 2) uses `req_bop` to choose the action: 1 sets the bit, 2 clears it, and 0 or 3 leaves it unchanged. `req_bsel` picks the bit within the nibble. Every bit request returns the bit's prior value on `rd_bit` and the prior nibble on `rd_data[3:0]`. A set or clear changes only the selected bit.
- R5: `gpr_hit` is high in the same cycle as a valid request to 0x000–0x003, and is low otherwise.
- R6: `stk_hit` is high in the same cycle as a valid request to 0x020–0x03F, and is low otherwise.
- R7: A valid, aligned request to 0xF80–0xFFF raises `per_req` in the same cycle with `per_addr` = address bits 6:0. It never alters the array. A read returns `per_rdata` (byte) or `{4'h0, per_rdata[3:0]}` (nibble) one cycle later. A bit request returns `per_rdata[bsel]` on `rd_bit`.
- R8: A valid, aligned request to 0x040–0xF7F sets `unmapped` in the next cycle. A read there returns zero data and a zero bit. A write there changes no storage.
- R9: `rd_valid` is high in the cycle after any aligned read request and any aligned bit request, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request valid this cycle |
| req_wr | input | 1 | Write for nibble/byte requests |
| req_kind | input | 2 | 0 nibble, 1 byte, 2 bit, 3 nibble |
| req_bop | input | 2 | Bit action: 0 test, 1 set, 2 clear, 3 test |
| req_bsel | input | 2 | Bit index within the nibble |
| req_addr | input | 12 | Data address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Registered read data |
| rd_bit | output | 1 | Registered selected bit (prior value) |
| misalign_err | output | 1 | Odd-address byte request pulse |
| unmapped | output | 1 | Unimplemented-region access pulse |
| gpr_hit | output | 1 | Request in general-register window |
| stk_hit | output | 1 | Request in stack window |
| per_req | output | 1 | Peripheral request |
| per_wr | output | 1 | Peripheral write (includes bit set/clear) |
| per_kind | output | 2 | Request width code passed through |
| per_bsel | output | 2 | Bit index passed through |
| per_addr | output | 7 | Offset within peripheral area |
| per_wdata | output | 8 | Peripheral write data; bit 0 is the set/clear value for bit requests |
| per_rdata | input | 8 | Peripheral read data, same cycle |

## Verification
Stored contents can only be seen through reads. For that reason, a wrong nibble, a swapped byte half or a bit write that spills into a neighbouring bit is detected at the first later read of that location, one cycle after that read is issued. A bad region decode or a bad misalignment decision shows up sooner. It either changes the same-cycle peripheral request and window flags, or it changes the `unmapped`/`misalign_err` pulses in the following cycle. A write that wrongly lands on an aliased RAM location is only exposed when that RAM location is read back later.

// File: rtl/nram_pkg.sv
package nram_pkg;
  typedef enum logic [1:0] {
    K_NIB  = 2'd0,
    K_BYTE = 2'd1,
    K_BIT  = 2'd2,
    K_ALT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    B_TEST = 2'd0,
    B_SET  = 2'd1,
    B_CLR  = 2'd2,
    B_PEEK = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    RG_RAM  = 2'd0,
    RG_PER  = 2'd1,
    RG_NONE = 2'd2
  } region_e;
endpackage

// File: rtl/nram_decode.sv
module nram_decode
  import nram_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEPTH     = 64,
  parameter int PER_BASE  = 'hF80,
  parameter int GPR_LAST  = 3,
  parameter int STK_FIRST = 'h20,
  parameter int STK_LAST  = 'h3F
) (
  input  logic              vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  output region_e           region,
  output logic              mis,
  output logic              gpr,
  output logic              stk
);
  localparam logic [ADDR_W-1:0] RAM_END = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] PER_LO  = ADDR_W'(PER_BASE);
  localparam logic [ADDR_W-1:0] GPR_HI  = ADDR_W'(GPR_LAST);
  localparam logic [ADDR_W-1:0] STK_LO  = ADDR_W'(STK_FIRST);
  localparam logic [ADDR_W-1:0] STK_HI  = ADDR_W'(STK_LAST);

  always_comb begin
    if (addr < RAM_END)      region = RG_RAM;
    else if (addr >= PER_LO) region = RG_PER;
    else                     region = RG_NONE;
  end

  always_comb begin
    mis = vld && (kind_e'(kind) == K_BYTE) && addr[0];
    gpr = vld && (addr <= GPR_HI);
    stk = vld && (addr >= STK_LO) && (addr <= STK_HI);
  end
endmodule

// File: rtl/nram_bitop.sv
module nram_bitop
  import nram_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int SEL_W = $clog2(NIB_W)
) (
  input  logic [NIB_W-1:0] old_nib,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       op,
  output logic [NIB_W-1:0] new_nib,
  output logic             old_bit,
  output logic             modifies
);
  logic [NIB_W-1:0] mask;

  always_comb begin
    mask     = '0;
    mask[sel] = 1'b1;
    old_bit  = old_nib[sel];
    modifies = 1'b0;
    new_nib  = old_nib;
    case (bop_e'(op))
      B_SET: begin
        new_nib  = old_nib | mask;
        modifies = 1'b1;
      end
      B_CLR: begin
        new_nib  = old_nib & ~mask;
        modifies = 1'b1;
      end
      default: new_nib = old_nib;
    endcase
  end
endmodule

// File: rtl/nram_array.sv
module nram_array #(
  parameter int DEPTH = 64,
  parameter int NIB_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_lo,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [NIB_W-1:0] wd_lo,
  input  logic [NIB_W-1:0] wd_hi,
  output logic [NIB_W-1:0] rd_lo,
  output logic [NIB_W-1:0] rd_hi
);
  logic [NIB_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_hi;

  assign idx_hi = {idx_lo[IDX_W-1:1], 1'b1};

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic             hit_lo;
    logic             hit_hi;
    logic             en;
    logic [NIB_W-1:0] d;

    always_comb begin
      hit_lo = we_lo && (idx_lo == IDX_W'(w));
      hit_hi = we_hi && (idx_hi == IDX_W'(w));
      en     = hit_lo || hit_hi;
      d      = hit_lo ? wd_lo : wd_hi;
    end

    always_ff @(posedge clk) begin
      if (en) mem[w] <= d;
    end
  end

  assign rd_lo = mem[idx_lo];
  assign rd_hi = mem[idx_hi];

  // R2
  hi_pairs_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi |-> (we_lo && !idx_lo[0]));
endmodule

// File: rtl/nram_core.sv
module nram_core
  import nram_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEPTH     = 64,
  parameter int NIB_W     = 4,
  parameter int PER_BASE  = 'hF80,
  parameter int GPR_LAST  = 3,
  parameter int STK_FIRST = 'h20,
  parameter int STK_LAST  = 'h3F,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int SEL_W    = $clog2(NIB_W),
  localparam int DAT_W    = 2 * NIB_W,
  localparam int PER_W    = $clog2((1 << ADDR_W) - PER_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_bop,
  input  logic [SEL_W-1:0]  req_bsel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DAT_W-1:0]  req_wdata,
  output logic              rd_valid,
  output logic [DAT_W-1:0]  rd_data,
  output logic              rd_bit,
  output logic              misalign_err,
  output logic              unmapped,
  output logic              gpr_hit,
  output logic              stk_hit,
  output logic              per_req,
  output logic              per_wr,
  output logic [1:0]        per_kind,
  output logic [SEL_W-1:0]  per_bsel,
  output logic [PER_W-1:0]  per_addr,
  output logic [DAT_W-1:0]  per_wdata,
  input  logic [DAT_W-1:0]  per_rdata
);
  region_e          region;
  logic             mis;
  logic             ram_sel, per_sel, none_sel;
  logic             is_bit, is_byte;
  logic             bit_mod, bit_old;
  logic [NIB_W-1:0] bit_new;
  logic             we_lo, we_hi;
  logic [NIB_W-1:0] wd_lo, rd_lo, rd_hi;
  logic             rd_cycle;

  logic             valid_n, bit_n, mis_n, unm_n;
  logic [DAT_W-1:0] data_n;

  nram_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PER_BASE(PER_BASE),
    .GPR_LAST(GPR_LAST), .STK_FIRST(STK_FIRST), .STK_LAST(STK_LAST)
  ) u_decode (
    .vld(req_vld), .addr(req_addr), .kind(req_kind),
    .region(region), .mis(mis), .gpr(gpr_hit), .stk(stk_hit)
  );

  nram_bitop #(.NIB_W(NIB_W)) u_bitop (
    .old_nib(rd_lo), .sel(req_bsel), .op(req_bop),
    .new_nib(bit_new), .old_bit(bit_old), .modifies(bit_mod)
  );

  nram_array #(.DEPTH(DEPTH), .NIB_W(NIB_W)) u_array (
    .clk(clk), .rst_n(rst_n), .idx_lo(req_addr[IDX_W-1:0]),
    .we_lo(we_lo), .we_hi(we_hi), .wd_lo(wd_lo), .wd_hi(req_wdata[DAT_W-1:NIB_W]),
    .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  // Request qualification and write steering
  always_comb begin
    is_bit   = kind_e'(req_kind) == K_BIT;
    is_byte  = kind_e'(req_kind) == K_BYTE;
    ram_sel  = req_vld && !mis && (region == RG_RAM);
    per_sel  = req_vld && !mis && (region == RG_PER);
    none_sel = req_vld && !mis && (region == RG_NONE);
    rd_cycle = is_bit || !req_wr;
    we_lo    = ram_sel && (is_bit ? bit_mod : req_wr);
    we_hi    = ram_sel && is_byte && req_wr;
    wd_lo    = is_bit ? bit_new : req_wdata[NIB_W-1:0];
  end

  // Peripheral forwarding
  always_comb begin
    per_req   = per_sel;
    per_wr    = per_sel && (is_bit ? bit_mod : req_wr);
    per_kind  = req_kind;
    per_bsel  = req_bsel;
    per_addr  = req_addr[PER_W-1:0];
    per_wdata = is_bit ? DAT_W'(bop_e'(req_bop) == B_SET) : req_wdata;
  end

  // Next state of the registered response
  always_comb begin
    valid_n = (ram_sel || per_sel || none_sel) && rd_cycle;
    mis_n   = mis;
    unm_n   = none_sel;
    data_n  = '0;
    bit_n   = 1'b0;
    if (ram_sel) begin
      data_n = is_byte ? {rd_hi, rd_lo} : {{NIB_W{1'b0}}, rd_lo};
      bit_n  = is_bit && bit_old;
    end else if (per_sel) begin
      data_n = is_byte ? per_rdata : {{NIB_W{1'b0}}, per_rdata[NIB_W-1:0]};
      bit_n  = is_bit && per_rdata[req_bsel];
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      misalign_err <= 1'b0;
      unmapped     <= 1'b0;
      rd_data      <= '0;
      rd_bit       <= 1'b0;
    end else begin
      rd_valid     <= valid_n;
      misalign_err <= mis_n;
      unmapped     <= unm_n;
      if (req_vld) begin
        rd_data <= data_n;
        rd_bit  <= bit_n;
      end
    end
  end

  // R3
  misalign_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> $past(req_vld && (req_kind == 2'd1) && req_addr[0]));
  // R3
  misalign_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_kind == 2'd1) && req_addr[0]) |-> !(we_lo || we_hi || per_req));
  // R7
  per_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> !(we_lo || we_hi));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rd_data == '0 && !rd_bit));
  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_vld));
  // R4
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && is_bit) |-> ($countones(wd_lo ^ rd_lo) <= 1));
endmodule

// File: tb/nram_core_bench.sv
module nram_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr;
  logic [1:0]  req_kind, req_bop, req_bsel;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid, rd_bit, misalign_err, unmapped, gpr_hit, stk_hit;
  logic [7:0]  rd_data;
  logic        per_req, per_wr;
  logic [1:0]  per_kind, per_bsel;
  logic [6:0]  per_addr;
  logic [7:0]  per_wdata, per_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] mdl [64];

  always #5 clk = ~clk;

  assign per_rdata = {1'b0, per_addr} ^ 8'hC3;

  nram_core u_nram_core (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_kind(req_kind), .req_bop(req_bop), .req_bsel(req_bsel),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .misalign_err(misalign_err), .unmapped(unmapped),
    .gpr_hit(gpr_hit), .stk_hit(stk_hit),
    .per_req(per_req), .per_wr(per_wr), .per_kind(per_kind), .per_bsel(per_bsel),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int region_of(input logic [11:0] a);
    if (a < 12'h040) return 0;
    if (a >= 12'hF80) return 1;
    return 2;
  endfunction

  function automatic logic [7:0] per_model(input logic [11:0] a);
    return {1'b0, a[6:0]} ^ 8'hC3;
  endfunction

  task automatic access(input logic [1:0] kind, input bit wr, input logic [1:0] op,
                        input logic [1:0] sel, input logic [11:0] a, input logic [7:0] wd);
    int rg;
    bit mis, rd, bitk, bmod;
    logic [7:0] e_data;
    logic e_bit;
    logic [5:0] ix;
    rg   = region_of(a);
    mis  = (kind == 2'd1) && a[0];
    bitk = (kind == 2'd2);
    bmod = bitk && (op == 2'd1 || op == 2'd2);
    rd   = !mis && (bitk || !wr);
    ix   = a[5:0];
    @(negedge clk);
    req_vld = 1; req_wr = wr; req_kind = kind; req_bop = op;
    req_bsel = sel; req_addr = a; req_wdata = wd;
    #1;
    chk(gpr_hit == (a <= 12'h003), "R5", gpr_hit, a <= 12'h003);
    chk(stk_hit == (a >= 12'h020 && a <= 12'h03F), "R6", stk_hit, 0);
    chk(per_req == (!mis && rg == 1), "R7", per_req, !mis && rg == 1);
    if (per_req) begin
      chk(per_addr == a[6:0], "R7", per_addr, a[6:0]);
      chk(per_wr == (bitk ? bmod : wr), "R7", per_wr, bitk ? bmod : wr);
    end
    e_data = 8'h00; e_bit = 1'b0;
    if (!mis && rg == 0) begin
      e_data = (kind == 2'd1) ? {mdl[ix | 6'd1], mdl[ix]} : {4'h0, mdl[ix]};
      e_bit  = bitk && mdl[ix][sel];
    end else if (!mis && rg == 1) begin
      e_data = (kind == 2'd1) ? per_model(a) : {4'h0, per_model(a)[3:0]};
      e_bit  = bitk && per_model(a)[sel];
    end
    @(posedge clk);
    #1;
    chk(misalign_err == mis, "R3", misalign_err, mis);
    chk(unmapped == (!mis && rg == 2), "R8", unmapped, !mis && rg == 2);
    chk(rd_valid == rd, "R9", rd_valid, rd);
    if (rd) begin
      chk(rd_data == e_data, (kind == 2'd1) ? "R2" : (rg == 2 ? "R8" : "R1"), rd_data, e_data);
      if (bitk) chk(rd_bit == e_bit, "R4", rd_bit, e_bit);
    end
    if (!mis && rg == 0) begin
      if (bitk) begin
        if (op == 2'd1) mdl[ix][sel] = 1'b1;
        if (op == 2'd2) mdl[ix][sel] = 1'b0;
      end else if (wr) begin
        mdl[ix] = wd[3:0];
        if (kind == 2'd1) mdl[ix | 6'd1] = wd[7:4];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] ra;
    int pick;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; req_vld = 0; req_wr = 0; req_kind = 0; req_bop = 0;
    req_bsel = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rd_valid && !misalign_err && !unmapped, "R9", {rd_valid, misalign_err, unmapped}, 0);
    @(negedge clk); rst_n = 1;

    // R2: fill the whole array with byte writes
    for (int i = 0; i < 64; i += 2) access(2'd1, 1, 0, 0, 12'(i), 8'(i * 7 + 3));
    access(2'd1, 0, 0, 0, 12'h03E, 0);               // R2 top pair
    access(2'd0, 0, 0, 0, 12'h03F, 0);               // R1 high half alone
    access(2'd0, 1, 0, 0, 12'h010, 8'hFA);           // R1 nibble write, upper ignored
    access(2'd1, 0, 0, 0, 12'h010, 0);               // R2
    access(2'd3, 1, 0, 0, 12'h011, 8'h05);           // R1 code 3 acts as nibble
    access(2'd1, 0, 0, 0, 12'h010, 0);
    // R3: odd byte write leaves both neighbours intact
    access(2'd1, 1, 0, 0, 12'h005, 8'hEE);
    access(2'd1, 0, 0, 0, 12'h004, 0);
    access(2'd1, 0, 0, 0, 12'h006, 0);
    access(2'd1, 0, 0, 0, 12'hF81, 0);               // R3 in peripheral area
    // R4: bit actions on a stack location
    access(2'd0, 1, 0, 0, 12'h021, 8'h00);
    access(2'd2, 0, 2'd1, 2'd3, 12'h021, 0);
    access(2'd2, 0, 2'd0, 2'd3, 12'h021, 0);
    access(2'd2, 0, 2'd1, 2'd0, 12'h021, 0);
    access(2'd2, 0, 2'd2, 2'd3, 12'h021, 0);
    access(2'd2, 0, 2'd3, 2'd0, 12'h021, 0);
    access(2'd0, 0, 0, 0, 12'h021, 0);
    // R8: unmapped reads and writes, with aliases checked
    access(2'd1, 0, 0, 0, 12'h040, 0);
    access(2'd0, 1, 0, 0, 12'h045, 8'h0F);
    access(2'd2, 0, 2'd1, 2'd2, 12'h7C5, 0);
    access(2'd1, 1, 0, 0, 12'hF7E, 8'hFF);
    access(2'd1, 0, 0, 0, 12'h004, 0);
    access(2'd1, 0, 0, 0, 12'h03E, 0);
    // R7: peripheral edges, writes do not alias into the array
    access(2'd1, 0, 0, 0, 12'hF80, 0);
    access(2'd0, 0, 0, 0, 12'hFFF, 0);
    access(2'd1, 1, 0, 0, 12'hFBE, 8'h99);
    access(2'd2, 0, 2'd2, 2'd1, 12'hFFF, 0);
    access(2'd1, 0, 0, 0, 12'h03E, 0);
    // R5 R6: window edges
    access(2'd0, 0, 0, 0, 12'h003, 0);
    access(2'd0, 0, 0, 0, 12'h004, 0);
    access(2'd0, 0, 0, 0, 12'h01F, 0);
    access(2'd0, 0, 0, 0, 12'h020, 0);
    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      pick = int'($urandom % 10);
      if (pick < 6)      ra = 12'($urandom % 64);
      else if (pick < 8) ra = 12'h F80 + 12'($urandom % 128);
      else               ra = 12'h040 + 12'($urandom % 12'hF40);
      access(2'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), ra, 8'($urandom));
    end
    @(negedge clk); req_vld = 0;
    @(posedge clk); #1;
    chk(!rd_valid && !unmapped && !misalign_err, "R9", rd_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule